// File: doc/BRIEF.md
# Prioritized Two-Output Interrupt Controller

This block collects up to 32 interrupt request lines and presents them to a processor as two separate request outputs: a normal one and a fast one. Each line owns a small configuration word that gives it a 5-bit priority, chooses edge or level sensing, and picks which of the two outputs it competes for. Incoming requests are captured in pending bits. Software can clear those bits and can block any line with a mask bit.

The block runs two arbitrations, one per output, over the set of pending, unmasked lines that are routed to that output. A smaller priority value wins. When two lines have the same value, the smaller line index wins. Once a winner has been chosen, it is frozen together with its output line. Software reads the winner's index from a number register and services it. It then writes a re-arm bit in the control word, and the block runs a fresh arbitration for that output only.

Software reaches everything through a 16-bit register port with byte addresses. Writes take effect on the clock edge. Reads are combinational.

Top module: `prio_intc`

## Requirements
- R1: After reset, both pending words read 0x0000, both mask words read 0xFFFF, every configuration word reads 0, both number registers read 0, the control word reads 0, and irq_out and fiq_out are low.
- R2: Address map (byte addresses): pending for lines 0..15 at 0x00 and for lines 16..31 at 0x02, with bit k of each word holding line 16*word+k. Mask words at 0x08 and 0x0A, with the same bit order. Normal winner number at 0x10 and fast winner number at 0x12, both in bits 4:0. Control at 0x14. The configuration word of line n is at 0x20+2n, with bit 0 = route to fast output, bit 1 = edge sensing, and bits 6:2 = priority.
- R3: Writing a pending word clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R4: A level-sensed line sets its pending bit on every clock edge at which its input is high, so it cannot be cleared while the input stays high.
- R5: An edge-sensed line sets its pending bit only on a rising edge, which is detected against a registered copy of the input. Clearing the bit while the input stays high keeps it clear.
- R6: A mask bit of 1 removes its line from arbitration. The pending words still show the raw captured requests.
- R7: Among the candidates, the smallest priority value wins, and on equal values the smallest line index wins.
- R8: A line with route bit 1 takes part only in the fast arbitration. A line with route bit 0 takes part only in the normal arbitration.
- R9: While a winner is latched, its number and its output line stay unchanged until the matching re-arm. This holds even if the pending bit clears or a stronger request arrives.
- R10: Writing control bit 0 as 1 re-arms the normal arbitration, and writing bit 1 as 1 re-arms the fast one. Each path is independent of the other. A written bit reads back 1 for exactly one cycle and then returns to 0. The new arbitration happens on the clock edge at which the bit is cleared.
- R11: An output is high exactly while its path holds a latched winner. A re-arm with no candidates drives that output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | 32 | Raw request lines, one per source |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
The bench goes after equal-priority ties: a design that broke ties toward the larger index would report line 20 in place of line 7. It checks the freeze by raising stronger requests and clearing the winner's pending bit while a winner is latched. A design that re-arbitrates continuously would change the number or drop the output at that point. It also holds an edge-sensed input high across a pending clear, where a level-style implementation would set the bit again. Finally, it re-arms the two paths separately to catch controllers that share one re-arm between the outputs, or whose control bits stick instead of self-clearing.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
   // byte offsets decoded by software
   localparam int unsigned OFS_PEND  = 'h00;
   localparam int unsigned OFS_MASK  = 'h08;
   localparam int unsigned OFS_INUM  = 'h10;
   localparam int unsigned OFS_FNUM  = 'h12;
   localparam int unsigned OFS_CTRL  = 'h14;
   localparam int unsigned OFS_LVL   = 'h20;
   // configuration word fields
   localparam int unsigned CFG_ROUTE = 0;
   localparam int unsigned CFG_EDGE  = 1;
   localparam int unsigned CFG_PRIO  = 2;
   // control bits
   localparam int unsigned CTL_IRQ   = 0;
   localparam int unsigned CTL_FIQ   = 1;
   localparam int unsigned NPATH     = 2;
endpackage

// File: rtl/intc_pend.sv
module intc_pend #(
   parameter int NSRC = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src,
   input  logic [NSRC-1:0] edge_sel,
   input  logic [NSRC-1:0] clr,
   output logic [NSRC-1:0] pend
);
   logic [NSRC-1:0] src_q;
   logic [NSRC-1:0] set_v;

   genvar i;
   generate
      for (i = 0; i < NSRC; i++) begin : g_set
         assign set_v[i] = edge_sel[i] ? (src[i] & ~src_q[i]) : src[i];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= '0;
         pend  <= '0;
      end else begin
         src_q <= src;
         pend  <= (pend & ~clr) | set_v;
      end
   end
endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
   parameter int NSRC  = 32,
   parameter int PRIOW = 5,
   parameter int IDXW  = 5
) (
   input  logic [NSRC-1:0]       cand,
   input  logic [NSRC*PRIOW-1:0] prio_flat,
   output logic                  any,
   output logic [IDXW-1:0]       win
);
   logic [PRIOW-1:0] best;

   always_comb begin
      any  = 1'b0;
      win  = '0;
      best = '1;
      for (int i = 0; i < NSRC; i++) begin
         if (cand[i] && (!any || prio_flat[i*PRIOW +: PRIOW] < best)) begin
            any  = 1'b1;
            win  = IDXW'(i);
            best = prio_flat[i*PRIOW +: PRIOW];
         end
      end
   end
endmodule

// File: rtl/intc_hold.sv
module intc_hold #(
   parameter int IDXW = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            any,
   input  logic [IDXW-1:0] win,
   input  logic            rearm,
   output logic            valid,
   output logic [IDXW-1:0] num
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         num   <= '0;
      end else if (!valid || rearm) begin
         valid <= any;
         if (any) num <= win;
      end
   end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
   import prio_intc_pkg::*;
#(
   parameter int NSRC  = 32,
   parameter int REGW  = 16,
   parameter int ADDRW = 8,
   parameter int PRIOW = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSRC-1:0]  src_req,
   input  logic             bus_wr,
   input  logic [ADDRW-1:0] bus_addr,
   input  logic [REGW-1:0]  bus_wdata,
   output logic [REGW-1:0]  bus_rdata,
   output logic             irq_out,
   output logic             fiq_out
);
   localparam int IDXW  = $clog2(NSRC);
   localparam int NWORD = NSRC / REGW;
   localparam int LVLW  = PRIOW + 2;

   initial begin
      if (NWORD * REGW != NSRC) $error("NSRC must be a multiple of REGW");
      if (LVLW > REGW)          $error("configuration word wider than bus");
      if (OFS_LVL + 2 * NSRC > (1 << ADDRW)) $error("ADDRW too small");
   end

   logic [NSRC-1:0]       mask_q, pend, clr, route_fiq, edge_sel;
   logic [NSRC-1:0]       cand_irq, cand_fiq;
   logic [NSRC*PRIOW-1:0] prio_flat;
   logic [LVLW-1:0]       lvl_q [NSRC];
   logic [NPATH-1:0]      ctrl_q;
   logic [NWORD-1:0]      pend_hit, mask_hit;
   logic                  irq_any, fiq_any, fiq_valid, irq_valid;
   logic [IDXW-1:0]       irq_win, fiq_win, irq_num, fiq_num;
   logic [ADDRW-1:0]      lvl_off;
   logic [IDXW-1:0]       lvl_idx;
   logic                  lvl_hit, ctrl_hit;

   // ---------------- address decode ----------------
   assign lvl_off  = bus_addr - ADDRW'(OFS_LVL);
   assign lvl_idx  = lvl_off[IDXW:1];
   assign lvl_hit  = (bus_addr >= ADDRW'(OFS_LVL)) &&
                     (bus_addr <  ADDRW'(OFS_LVL + 2 * NSRC)) && !bus_addr[0];
   assign ctrl_hit = (bus_addr == ADDRW'(OFS_CTRL));

   genvar w, s;
   generate
      for (w = 0; w < NWORD; w++) begin : g_word
         assign pend_hit[w] = bus_wr && (bus_addr == ADDRW'(OFS_PEND + 2 * w));
         assign mask_hit[w] = bus_wr && (bus_addr == ADDRW'(OFS_MASK + 2 * w));
         assign clr[w*REGW +: REGW] = pend_hit[w] ? ~bus_wdata : '0;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           mask_q[w*REGW +: REGW] <= '1;
            else if (mask_hit[w]) mask_q[w*REGW +: REGW] <= bus_wdata;
         end
      end

      for (s = 0; s < NSRC; s++) begin : g_src
         assign route_fiq[s]               = lvl_q[s][CFG_ROUTE];
         assign edge_sel[s]                = lvl_q[s][CFG_EDGE];
         assign prio_flat[s*PRIOW +: PRIOW] = lvl_q[s][CFG_PRIO +: PRIOW];
      end
   endgenerate

   // ---------------- configuration and control ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NSRC; i++) lvl_q[i] <= '0;
      end else if (bus_wr && lvl_hit) begin
         lvl_q[lvl_idx] <= bus_wdata[LVLW-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= '0;
      else        ctrl_q <= (bus_wr && ctrl_hit) ? bus_wdata[NPATH-1:0] : '0;
   end

   // ---------------- capture, arbitrate, hold ----------------
   intc_pend #(.NSRC(NSRC)) u_pend (
      .clk(clk), .rst_n(rst_n), .src(src_req), .edge_sel(edge_sel),
      .clr(clr), .pend(pend));

   assign cand_irq = pend & ~mask_q & ~route_fiq;
   assign cand_fiq = pend & ~mask_q &  route_fiq;

   intc_arb #(.NSRC(NSRC), .PRIOW(PRIOW), .IDXW(IDXW)) u_arb_irq (
      .cand(cand_irq), .prio_flat(prio_flat), .any(irq_any), .win(irq_win));
   intc_arb #(.NSRC(NSRC), .PRIOW(PRIOW), .IDXW(IDXW)) u_arb_fiq (
      .cand(cand_fiq), .prio_flat(prio_flat), .any(fiq_any), .win(fiq_win));

   intc_hold #(.IDXW(IDXW)) u_hold_irq (
      .clk(clk), .rst_n(rst_n), .any(irq_any), .win(irq_win),
      .rearm(ctrl_q[CTL_IRQ]), .valid(irq_valid), .num(irq_num));
   intc_hold #(.IDXW(IDXW)) u_hold_fiq (
      .clk(clk), .rst_n(rst_n), .any(fiq_any), .win(fiq_win),
      .rearm(ctrl_q[CTL_FIQ]), .valid(fiq_valid), .num(fiq_num));

   assign irq_out = irq_valid;
   assign fiq_out = fiq_valid;

   // ---------------- read mux ----------------
   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NWORD; i++) begin
         if (bus_addr == ADDRW'(OFS_PEND + 2 * i)) bus_rdata = pend[i*REGW +: REGW];
         if (bus_addr == ADDRW'(OFS_MASK + 2 * i)) bus_rdata = mask_q[i*REGW +: REGW];
      end
      if (bus_addr == ADDRW'(OFS_INUM)) bus_rdata = REGW'(irq_num);
      if (bus_addr == ADDRW'(OFS_FNUM)) bus_rdata = REGW'(fiq_num);
      if (ctrl_hit)                     bus_rdata = REGW'(ctrl_q);
      if (lvl_hit)                      bus_rdata = REGW'(lvl_q[lvl_idx]);
   end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
   parameter int NSRC  = 32,
   parameter int REGW  = 16,
   parameter int ADDRW = 8,
   parameter int IDXW  = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq_out,
   input logic             fiq_out,
   input logic [IDXW-1:0]  irq_num,
   input logic [IDXW-1:0]  fiq_num,
   input logic [1:0]       ctrl_q,
   input logic [NSRC-1:0]  mask_q,
   input logic [NSRC-1:0]  cand_irq,
   input logic             bus_wr,
   input logic [ADDRW-1:0] bus_addr,
   input logic [REGW-1:0]  bus_wdata
);
   logic ctrl_wr;
   assign ctrl_wr = bus_wr && (bus_addr == ADDRW'('h14));

   AST_IRQ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out && !ctrl_q[0]) |=> (irq_out && $stable(irq_num))); // R9
   AST_FIQ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (fiq_out && !ctrl_q[1]) |=> (fiq_out && $stable(fiq_num))); // R9
   AST_CTRL_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ((ctrl_q != 2'b00) && !ctrl_wr) |=> (ctrl_q == 2'b00)); // R10
   AST_MASK_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDRW'('h08)) |=> (mask_q[REGW-1:0] == $past(bus_wdata))); // R2
   AST_IRQ_NEEDS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_out && cand_irq == '0) |=> !irq_out); // R11
endmodule

bind prio_intc prio_intc_chk #(.NSRC(NSRC), .REGW(REGW), .ADDRW(ADDRW), .IDXW(IDXW)) chk_i (
   .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .fiq_out(fiq_out),
   .irq_num(irq_num), .fiq_num(fiq_num), .ctrl_q(ctrl_q), .mask_q(mask_q),
   .cand_irq(cand_irq), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata));

// File: tb/prio_intc_tb_top.sv
`timescale 1ns/1ps
module prio_intc_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_req = '0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq_out, fiq_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   bit started = 0;

   always #5 clk = ~clk;

   prio_intc dut_i (.clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_out(irq_out), .fiq_out(fiq_out));

   // ---------------- behavioural reference ----------------
   bit [31:0] m_pend = '0, m_mask = '1, m_srcq = '0;
   int        m_lvl [32];
   bit [1:0]  m_ctrl = '0;
   bit        m_iv = 0, m_fv = 0;
   int        m_in = 0, m_fn = 0;

   initial for (int i = 0; i < 32; i++) m_lvl[i] = 0;

   task automatic pick(input int path, output bit any, output int w);
      int best;
      any = 0; w = 0; best = 99;
      for (int i = 0; i < 32; i++)
         if (m_pend[i] && !m_mask[i] && (m_lvl[i] & 1) == path &&
             ((m_lvl[i] >> 2) & 31) < best) begin
            any = 1; w = i; best = (m_lvl[i] >> 2) & 31;
         end
   endtask

   always @(posedge clk) begin
      bit ai, af; int wi, wf;
      if (!rst_n) begin
         m_pend = '0; m_mask = '1; m_srcq = '0; m_ctrl = '0;
         m_iv = 0; m_fv = 0; m_in = 0; m_fn = 0;
         for (int i = 0; i < 32; i++) m_lvl[i] = 0;
      end else begin
         pick(0, ai, wi);
         pick(1, af, wf);
         if (!m_iv || m_ctrl[0]) begin m_iv = ai; if (ai) m_in = wi; end
         if (!m_fv || m_ctrl[1]) begin m_fv = af; if (af) m_fn = wf; end
         for (int i = 0; i < 32; i++) begin
            bit st, cl;
            st = (m_lvl[i] & 2) != 0 ? (src_req[i] && !m_srcq[i]) : src_req[i];
            cl = bus_wr && (bus_addr == 8'(2 * (i / 16))) && !bus_wdata[i % 16];
            m_pend[i] = (m_pend[i] && !cl) || st;
         end
         m_ctrl = (bus_wr && bus_addr == 8'h14) ? bus_wdata[1:0] : 2'b00;
         if (bus_wr && bus_addr == 8'h08) m_mask[15:0]  = bus_wdata;
         if (bus_wr && bus_addr == 8'h0A) m_mask[31:16] = bus_wdata;
         if (bus_wr && bus_addr >= 8'h20 && bus_addr < 8'h60 && !bus_addr[0])
            m_lvl[(bus_addr - 8'h20) / 2] = bus_wdata & 16'h7F;
         m_srcq = src_req;
      end
      started = 1;
   end

   function automatic logic [15:0] rd_exp(input logic [7:0] a);
      if (a == 8'h00) return m_pend[15:0];
      if (a == 8'h02) return m_pend[31:16];
      if (a == 8'h08) return m_mask[15:0];
      if (a == 8'h0A) return m_mask[31:16];
      if (a == 8'h10) return 16'(m_in);
      if (a == 8'h12) return 16'(m_fn);
      if (a == 8'h14) return 16'(m_ctrl);
      if (a >= 8'h20 && a < 8'h60 && !a[0]) return 16'(m_lvl[(a - 8'h20) / 2]);
      return 16'h0000;
   endfunction

   // every-cycle comparison against the reference
   always @(negedge clk) begin
      if (started && !done) begin
         n_chk++;
         if (bus_rdata !== rd_exp(bus_addr) || irq_out !== m_iv || fiq_out !== m_fv) begin
            n_bad++;
            $display("FAIL model R2 addr=%h rdata=%h exp=%h irq=%b exp=%b fiq=%b exp=%b",
               bus_addr, bus_rdata, rd_exp(bus_addr), irq_out, m_iv, fiq_out, m_fv);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      tick();
      bus_wr = 0;
   endtask

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
      bus_addr = a;
      @(negedge clk);
      chk(tag, bus_rdata, exp);
      tick();
   endtask

   task automatic outs(input logic ei, input logic ef, input string tag);
      @(negedge clk);
      chk(tag, {14'b0, irq_out, fiq_out}, {14'b0, ei, ef});
      tick();
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      tick();
      // R1 reset state
      rd(8'h00, 16'h0000, "R1 pend lo");
      rd(8'h0A, 16'hFFFF, "R1 mask hi");
      rd(8'h2A, 16'h0000, "R1 cfg line5");
      rd(8'h14, 16'h0000, "R1 ctrl");
      outs(0, 0, "R1 outputs");
      // configuration (R2 layout)
      wr(8'h20 + 2*3,  16'h0010);  // line3 prio4 level normal
      wr(8'h20 + 2*7,  16'h0008);  // line7 prio2
      wr(8'h20 + 2*20, 16'h0008);  // line20 prio2
      wr(8'h20 + 2*9,  16'h0007);  // line9 prio1 edge fast
      wr(8'h20 + 2*25, 16'h0001);  // line25 prio0 level fast
      rd(8'h20 + 2*9, 16'h0007, "R2 cfg readback");
      wr(8'h08, 16'h0000);
      wr(8'h0A, 16'h0000);
      // single request
      src_req[3] = 1;
      repeat (3) tick();
      rd(8'h10, 16'd3, "R7 single winner");
      outs(1, 0, "R11 irq raised");
      // stronger requests while frozen
      src_req[7] = 1; src_req[20] = 1;
      repeat (3) tick();
      rd(8'h10, 16'd3, "R9 frozen winner");
      wr(8'h14, 16'h0001);
      rd(8'h14, 16'h0001, "R10 ctrl one cycle");
      rd(8'h14, 16'h0000, "R10 ctrl self clear");
      rd(8'h10, 16'd7, "R7 tie lower index");
      // clear pending of the winner
      src_req[7] = 0;
      wr(8'h00, 16'hFF7F);
      rd(8'h00, 16'h0008, "R3 clear one bit");
      rd(8'h10, 16'd7, "R9 hold after clear");
      wr(8'h14, 16'h0001);
      tick();
      rd(8'h10, 16'd20, "R2 upper word line");
      rd(8'h02, 16'h0010, "R2 pend hi");
      // fast path
      src_req[9] = 1;
      repeat (3) tick();
      rd(8'h12, 16'd9, "R8 fast winner");
      rd(8'h10, 16'd20, "R8 normal unaffected");
      outs(1, 1, "R8 both outputs");
      wr(8'h00, 16'hFDFF);
      tick();
      rd(8'h00, 16'h0008, "R5 edge stays clear");
      src_req[25] = 1;
      repeat (3) tick();
      rd(8'h12, 16'd9, "R9 fast frozen");
      wr(8'h14, 16'h0002);
      tick();
      rd(8'h12, 16'd25, "R10 fast rearm");
      rd(8'h10, 16'd20, "R10 normal independent");
      // level cannot be cleared while high
      wr(8'h00, 16'hFFF7);
      tick();
      rd(8'h00, 16'h0008, "R4 level reasserts");
      // masking
      wr(8'h08, 16'hFFFF);
      wr(8'h0A, 16'hFFFF);
      rd(8'h02, 16'h0210, "R6 raw pending visible");
      wr(8'h14, 16'h0003);
      tick();
      outs(0, 0, "R6 masked no winner");
      outs(0, 0, "R11 low after empty rearm");
      // unmask lower word only: line3 returns
      wr(8'h08, 16'h0000);
      wr(8'h14, 16'h0001);
      tick();
      rd(8'h10, 16'd3, "R6 unmasked line wins");
      done = 1;
      summary();
   end
endmodule